// File: doc/BRIEF.md
# Processor Bus Port Decoder and Bus Master

This block sits on the FPGA side of an 8-bit processor bus and plays two roles on the same wires. As a slave, it decodes a window of 32 readable and 32 writable I/O ports. It holds the processor in wait until the user logic behind a port has taken the write data or returned the read data, so software never has to poll a status port. As a master, it takes a queue of transfer commands. For each command it requests the bus, waits for the acknowledge, and then drives address, data and memory or I/O strobes itself. When done, it either keeps the bus for the next command or hands it back.

The user side is made of streams:
- **Port writes** leave on `wp_valid_o`/`wp_ready_i`. Index and data are stable while valid is high. The processor stays in wait until the handshake.
- **Port reads** are a request/response pair. `rp_req_o` is held until the user logic pulses `rp_valid_i` with the data.
- **Commands** enter on `cmd_valid_i`/`cmd_ready_o`. The fields must be held stable while valid is high. Ready is only high while the bus is granted or retained.
- **Read results** leave on `rsp_valid_o`/`rsp_ready_i`. Valid and data are held until ready, and the bus transfer sequence stalls meanwhile.

Two level-sensitive maskable interrupt requests and a non-maskable interrupt pulse generator complete the processor-facing side.

All processor-side strobes are active low and sampled on the FPGA clock. `busrq_oe_o` high means the open-drain bus request line is pulled low; low means it is released.

Top module: `hostbus_bridge`

## Requirements
- R1: After reset, wait is released (1), bus request is released (`busrq_oe_o`=0), the bus drivers are off, all master strobes are high, the interrupt outputs are inactive (all 1), and `bus_dout_oe_o` is 0.
- R2: An I/O write with `cpu_addr_i[7:5]` equal to PORT_BASE pulls `cpu_wait_n_o` low in the same cycle. It then presents `wp_valid_o` with index `cpu_addr_i[4:0]` and the written byte. Wait is released in the cycle after the `wp_valid_o`/`wp_ready_i` handshake.
- R3: An I/O read in the window pulls wait low and raises `rp_req_o` with the index. In the cycle after `rp_valid_i`, wait is released and the returned byte is driven on `bus_dout_o` with `bus_dout_oe_o`=1. Driving stops once the read strobe ends.
- R4: Reads and writes outside the port window, and read or write strobes without the I/O strobe, leave wait high and raise neither `wp_valid_o` nor `rp_req_o`.
- R5: A pending command raises `busrq_oe_o`. The block drives no address, data or strobe unless the acknowledge (`busack_n_i`=0) was seen low in the previous cycle and is still low.
- R6: Each transfer drives the command address, then one strobe pair for `STB_CYC` cycles:
  - I/O strobe if `cmd_io_i`=1, memory strobe otherwise;
  - write strobe if `cmd_wr_i`=1, read strobe otherwise;
  - on a write, the command data is driven on `bus_dout_o`.
- R7: For a read command, the byte on `bus_din_i` at the last strobe cycle is returned on `rsp_data_o`. `rsp_valid_o` and `rsp_data_o` stay stable until `rsp_ready_i`.
- R8: A command with `cmd_hold_i`=1 keeps bus request and the drivers on after it ends. A command with `cmd_hold_i`=0 turns the drivers off and releases bus request in the same cycle. The block becomes idle only once the acknowledge has gone high.
- R9: `irq_n_o[i]` equals the inverse of `irq_req_i[i]`, one cycle later. A rising edge on `nmi_req_i` drives `nmi_n_o` low for exactly `NMI_W` cycles, however long the request stays high.
- R10: While the processor bus is granted to this block, in-window processor I/O accesses are not decoded: wait stays high and no port stream is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | IO_AW | Processor I/O port address |
| cpu_data_i | input | DATA_W | Processor write data |
| cpu_iorq_n_i | input | 1 | Processor I/O strobe |
| cpu_rd_n_i | input | 1 | Processor read strobe |
| cpu_wr_n_i | input | 1 | Processor write strobe |
| cpu_wait_n_o | output | 1 | Wait to processor, low stretches the access |
| wp_valid_o | output | 1 | Port write valid |
| wp_ready_i | input | 1 | Port write ready |
| wp_idx_o | output | IDX_W | Port write index |
| wp_data_o | output | DATA_W | Port write data |
| rp_req_o | output | 1 | Port read request |
| rp_idx_o | output | IDX_W | Port read index |
| rp_valid_i | input | 1 | Port read data valid (one cycle) |
| rp_data_i | input | DATA_W | Port read data |
| cmd_valid_i | input | 1 | Transfer command valid |
| cmd_ready_o | output | 1 | Transfer command ready |
| cmd_wr_i | input | 1 | Command direction, 1 = write |
| cmd_io_i | input | 1 | Command space, 1 = I/O, 0 = memory |
| cmd_hold_i | input | 1 | Keep the bus after this command |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_data_i | input | DATA_W | Command write data |
| rsp_valid_o | output | 1 | Read result valid |
| rsp_ready_i | input | 1 | Read result ready |
| rsp_data_o | output | DATA_W | Read result data |
| busrq_oe_o | output | 1 | Pull bus request low (open drain) |
| busack_n_i | input | 1 | Bus acknowledge, active low |
| bus_oe_o | output | 1 | Enable for address and strobe drivers |
| bus_addr_o | output | ADDR_W | Master address |
| bus_mreq_n_o | output | 1 | Master memory strobe |
| bus_iorq_n_o | output | 1 | Master I/O strobe |
| bus_rd_n_o | output | 1 | Master read strobe |
| bus_wr_n_o | output | 1 | Master write strobe |
| bus_din_i | input | DATA_W | Data bus input |
| bus_dout_o | output | DATA_W | Data bus output |
| bus_dout_oe_o | output | 1 | Data bus driver enable |
| irq_req_i | input | IRQ_N | Maskable interrupt requests |
| irq_n_o | output | IRQ_N | Maskable interrupt lines, active low |
| nmi_req_i | input | 1 | Non-maskable interrupt trigger |
| nmi_n_o | output | 1 | Non-maskable interrupt line, active low |

## Verification
The bench builds the block with PORT_BASE=5, STB_CYC=3 and NMI_W=5.

A non-zero base with a 3-bit window field lets near-miss addresses on either side of the window (base±1 with edge indices 0 and 31) exercise the decoder. A three-cycle strobe makes an off-by-one in the strobe counter visible as a wrong measured width. A five-cycle interrupt pulse is short enough to measure exactly while holding the request longer than the pulse.

Bus acknowledge follows the request with a two-cycle lag. This exposes both the grant gap before driving and the wait for acknowledge after release.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    SL_IDLE,
    SL_BUSY,
    SL_DONE
  } slv_st_e;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_REQ,
    MS_GNT,
    MS_SETUP,
    MS_STB,
    MS_RSP,
    MS_OWN,
    MS_REL
  } mst_st_e;
endpackage

// File: rtl/hb_slave.sv
module hb_slave
  import hb_pkg::*;
#(
  parameter int IO_AW     = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 5,
  parameter int PORT_BASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [IO_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iorq_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  output logic              wait_n_o,
  output logic              wp_valid_o,
  input  logic              wp_ready_i,
  output logic              rp_req_o,
  input  logic              rp_valid_i,
  input  logic [DATA_W-1:0] rp_data_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dout_oe_o
);
  localparam int BASE_W = IO_AW - IDX_W;
  localparam logic [BASE_W-1:0] BASE_V = BASE_W'(PORT_BASE);

  slv_st_e st;
  logic    is_rd;
  logic    strobe_act, hit;

  assign strobe_act = !iorq_n_i && (!rd_n_i || !wr_n_i);
  assign hit        = strobe_act && en_i && (addr_i[IO_AW-1:IDX_W] == BASE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SL_IDLE;
      is_rd   <= 1'b0;
      idx_o   <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      case (st)
        SL_IDLE: if (hit) begin
          st      <= SL_BUSY;
          is_rd   <= !rd_n_i;
          idx_o   <= addr_i[IDX_W-1:0];
          wdata_o <= data_i;
        end
        SL_BUSY: begin
          if (is_rd && rp_valid_i) begin
            rdata_o <= rp_data_i;
            st      <= SL_DONE;
          end else if (!is_rd && wp_ready_i) begin
            st <= SL_DONE;
          end
        end
        default: if (!strobe_act) st <= SL_IDLE;
      endcase
    end
  end

  assign wait_n_o   = !((st == SL_IDLE && hit) || st == SL_BUSY);
  assign wp_valid_o = (st == SL_BUSY) && !is_rd;
  assign rp_req_o   = (st == SL_BUSY) && is_rd;
  assign dout_oe_o  = (st == SL_DONE) && is_rd && !iorq_n_i && !rd_n_i;
endmodule

// File: rtl/hb_master.sv
module hb_master
  import hb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int STB_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_wr_i,
  input  logic              cmd_io_i,
  input  logic              cmd_hold_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  input  logic              busack_n_i,
  input  logic [DATA_W-1:0] bus_din_i,
  output logic              busrq_oe_o,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              mreq_n_o,
  output logic              iorq_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wdata_oe_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(STB_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_CYC - 1);

  mst_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic             c_wr, c_io, c_hold;
  logic             take, strobe;

  assign take = cmd_ready_o && cmd_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= MS_IDLE;
      cnt        <= '0;
      c_wr       <= 1'b0;
      c_io       <= 1'b0;
      c_hold     <= 1'b0;
      bus_addr_o <= '0;
      wdata_o    <= '0;
      rsp_data_o <= '0;
    end else begin
      if (take) begin
        c_wr       <= cmd_wr_i;
        c_io       <= cmd_io_i;
        c_hold     <= cmd_hold_i;
        bus_addr_o <= cmd_addr_i;
        wdata_o    <= cmd_data_i;
      end
      case (st)
        MS_IDLE:  if (cmd_valid_i) st <= MS_REQ;
        MS_REQ:   if (!busack_n_i) st <= MS_GNT;
        MS_GNT:   st <= cmd_valid_i ? MS_SETUP : MS_REL;
        MS_OWN:   if (cmd_valid_i) st <= MS_SETUP;
        MS_SETUP: begin
          cnt <= '0;
          st  <= MS_STB;
        end
        MS_STB: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) begin
            if (!c_wr) begin
              rsp_data_o <= bus_din_i;
              st         <= MS_RSP;
            end else begin
              st <= c_hold ? MS_OWN : MS_REL;
            end
          end
        end
        MS_RSP:   if (rsp_ready_i) st <= c_hold ? MS_OWN : MS_REL;
        default:  if (busack_n_i) st <= MS_IDLE;
      endcase
    end
  end

  assign strobe      = (st == MS_STB);
  assign cmd_ready_o = (st == MS_GNT) || (st == MS_OWN);
  assign rsp_valid_o = (st == MS_RSP);
  assign busrq_oe_o  = !(st == MS_IDLE || st == MS_REL);
  assign bus_oe_o    = (st == MS_SETUP) || (st == MS_STB) || (st == MS_RSP) || (st == MS_OWN);
  assign mreq_n_o    = !(strobe && !c_io);
  assign iorq_n_o    = !(strobe && c_io);
  assign rd_n_o      = !(strobe && !c_wr);
  assign wr_n_o      = !(strobe && c_wr);
  assign wdata_oe_o  = c_wr && ((st == MS_SETUP) || strobe);
  assign busy_o      = (st != MS_IDLE);
endmodule

// File: rtl/hb_irq.sv
module hb_irq #(
  parameter int IRQ_N = 2,
  parameter int NMI_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] irq_req_i,
  output logic [IRQ_N-1:0] irq_n_o,
  input  logic             nmi_req_i,
  output logic             nmi_n_o
);
  localparam int CNT_W = $clog2(NMI_W + 1);

  logic [CNT_W-1:0] cnt;
  logic             req_q;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_o[g] <= 1'b1;
      else        irq_n_o[g] <= !irq_req_i[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= nmi_req_i;
      if (nmi_req_i && !req_q) cnt <= CNT_W'(NMI_W);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
    end
  end

  assign nmi_n_o = (cnt == '0);
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge #(
  parameter int IO_AW     = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 5,
  parameter int PORT_BASE = 5,
  parameter int STB_CYC   = 3,
  parameter int IRQ_N     = 2,
  parameter int NMI_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_iorq_n_i,
  input  logic              cpu_rd_n_i,
  input  logic              cpu_wr_n_i,
  output logic              cpu_wait_n_o,
  output logic              wp_valid_o,
  input  logic              wp_ready_i,
  output logic [IDX_W-1:0]  wp_idx_o,
  output logic [DATA_W-1:0] wp_data_o,
  output logic              rp_req_o,
  output logic [IDX_W-1:0]  rp_idx_o,
  input  logic              rp_valid_i,
  input  logic [DATA_W-1:0] rp_data_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_wr_i,
  input  logic              cmd_io_i,
  input  logic              cmd_hold_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              busrq_oe_o,
  input  logic              busack_n_i,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_mreq_n_o,
  output logic              bus_iorq_n_o,
  output logic              bus_rd_n_o,
  output logic              bus_wr_n_o,
  input  logic [DATA_W-1:0] bus_din_i,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_dout_oe_o,
  input  logic [IRQ_N-1:0]  irq_req_i,
  output logic [IRQ_N-1:0]  irq_n_o,
  input  logic              nmi_req_i,
  output logic              nmi_n_o
);
  logic              m_busy, m_wd_oe, s_oe;
  logic [DATA_W-1:0] m_wdata, s_rdata;
  logic [IDX_W-1:0]  s_idx;

  hb_slave #(
    .IO_AW(IO_AW), .DATA_W(DATA_W), .IDX_W(IDX_W), .PORT_BASE(PORT_BASE)
  ) u_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (busack_n_i && !m_busy),
    .addr_i     (cpu_addr_i),
    .data_i     (cpu_data_i),
    .iorq_n_i   (cpu_iorq_n_i),
    .rd_n_i     (cpu_rd_n_i),
    .wr_n_i     (cpu_wr_n_i),
    .wait_n_o   (cpu_wait_n_o),
    .wp_valid_o (wp_valid_o),
    .wp_ready_i (wp_ready_i),
    .rp_req_o   (rp_req_o),
    .rp_valid_i (rp_valid_i),
    .rp_data_i  (rp_data_i),
    .idx_o      (s_idx),
    .wdata_o    (wp_data_o),
    .rdata_o    (s_rdata),
    .dout_oe_o  (s_oe)
  );

  hb_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_CYC(STB_CYC)
  ) u_master (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .cmd_wr_i    (cmd_wr_i),
    .cmd_io_i    (cmd_io_i),
    .cmd_hold_i  (cmd_hold_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_data_i  (cmd_data_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_data_o  (rsp_data_o),
    .busack_n_i  (busack_n_i),
    .bus_din_i   (bus_din_i),
    .busrq_oe_o  (busrq_oe_o),
    .bus_oe_o    (bus_oe_o),
    .bus_addr_o  (bus_addr_o),
    .mreq_n_o    (bus_mreq_n_o),
    .iorq_n_o    (bus_iorq_n_o),
    .rd_n_o      (bus_rd_n_o),
    .wr_n_o      (bus_wr_n_o),
    .wdata_o     (m_wdata),
    .wdata_oe_o  (m_wd_oe),
    .busy_o      (m_busy)
  );

  hb_irq #(.IRQ_N(IRQ_N), .NMI_W(NMI_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req_i (irq_req_i),
    .irq_n_o   (irq_n_o),
    .nmi_req_i (nmi_req_i),
    .nmi_n_o   (nmi_n_o)
  );

  assign wp_idx_o      = s_idx;
  assign rp_idx_o      = s_idx;
  assign bus_dout_o    = s_oe ? s_rdata : m_wdata;
  assign bus_dout_oe_o = s_oe || m_wd_oe;
endmodule

// File: rtl/hostbus_bridge_chk.sv
module hostbus_bridge_chk #(
  parameter int IO_AW     = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 5,
  parameter int PORT_BASE = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IO_AW-1:0]  cpu_addr_i,
  input logic              cpu_iorq_n_i,
  input logic              cpu_rd_n_i,
  input logic              cpu_wait_n_o,
  input logic              wp_valid_o,
  input logic              wp_ready_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              busrq_oe_o,
  input logic              busack_n_i,
  input logic              bus_oe_o,
  input logic              bus_mreq_n_o,
  input logic              bus_iorq_n_o,
  input logic              bus_rd_n_o,
  input logic              bus_wr_n_o,
  input logic              bus_dout_oe_o
);
  localparam int BASE_W = IO_AW - IDX_W;
  localparam logic [BASE_W-1:0] BASE_V = BASE_W'(PORT_BASE);

  // R2: a pending port write keeps the processor waiting
  a_r2_wait_covers_write: assert property (@(posedge clk) disable iff (!rst_n)
    wp_valid_o && !wp_ready_i |-> !cpu_wait_n_o);

  // R3: when wait lifts on an in-window read, the data bus is driven
  a_r3_read_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_iorq_n_i && !cpu_rd_n_i && busack_n_i && cpu_wait_n_o &&
     cpu_addr_i[IO_AW-1:IDX_W] == BASE_V && $past(!cpu_wait_n_o) && $past(!cpu_rd_n_i))
    |-> bus_dout_oe_o);

  // R5: drivers only after acknowledge was low a full cycle
  a_r5_no_drive_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> !busack_n_i && $past(!busack_n_i));

  // R6: at most one space strobe and one direction strobe at a time
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!bus_rd_n_o, !bus_wr_n_o}) && $onehot0({!bus_mreq_n_o, !bus_iorq_n_o}));

  // R1/R5: strobes stay high whenever drivers are off
  a_r5_strobes_idle_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> bus_rd_n_o && bus_wr_n_o && bus_mreq_n_o && bus_iorq_n_o);

  // R7: a read result is held under back-pressure
  a_r7_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o));

  // R8: bus request never lets go while drivers remain on
  a_r8_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busrq_oe_o) |-> !bus_oe_o);
endmodule

bind hostbus_bridge hostbus_bridge_chk #(
  .IO_AW(IO_AW), .DATA_W(DATA_W), .IDX_W(IDX_W), .PORT_BASE(PORT_BASE)
) u_chk (.*);

// File: tb/hostbus_bridge_tb.sv
module hostbus_bridge_tb;
  localparam int IO_AW = 8, ADDR_W = 16, DATA_W = 8, IDX_W = 5;
  localparam int PORT_BASE = 5, STB_CYC = 3, IRQ_N = 2, NMI_W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [IO_AW-1:0] cpu_addr_i;
  logic [DATA_W-1:0] cpu_data_i, rp_data_i, cmd_data_i, rsp_data_o, bus_din_i, bus_dout_o;
  logic cpu_iorq_n_i, cpu_rd_n_i, cpu_wr_n_i, cpu_wait_n_o;
  logic wp_valid_o, wp_ready_i, rp_req_o, rp_valid_i;
  logic [IDX_W-1:0] wp_idx_o, rp_idx_o;
  logic [DATA_W-1:0] wp_data_o;
  logic cmd_valid_i, cmd_ready_o, cmd_wr_i, cmd_io_i, cmd_hold_i;
  logic [ADDR_W-1:0] cmd_addr_i, bus_addr_o;
  logic rsp_valid_o, rsp_ready_i, busrq_oe_o, busack_n_i, bus_oe_o;
  logic bus_mreq_n_o, bus_iorq_n_o, bus_rd_n_o, bus_wr_n_o, bus_dout_oe_o;
  logic [IRQ_N-1:0] irq_req_i, irq_n_o;
  logic nmi_req_i, nmi_n_o;

  hostbus_bridge #(.PORT_BASE(PORT_BASE), .STB_CYC(STB_CYC), .NMI_W(NMI_W)) u_dut (.*);

  int errs = 0, checks = 0, xfer_cnt = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] port_val(input logic [4:0] i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [7:0] init_val(input logic [7:0] a, input bit io);
    return io ? (a ^ 8'hA5) : 8'(a * 3 + 1);
  endfunction

  // memory / IO models on the master side, plus bench shadow copies
  logic [7:0] mem [256];
  logic [7:0] iom [256];
  logic [7:0] sh_mem [256];
  logic [7:0] sh_io [256];
  assign bus_din_i = !bus_iorq_n_o ? iom[bus_addr_o[7:0]] : mem[bus_addr_o[7:0]];

  // current command as seen by the monitor
  bit cur_wr, cur_io;
  logic [15:0] cur_addr;
  logic [7:0] cur_data;

  // bus monitor and acknowledge model (ack follows request two cycles late)
  logic [1:0] ack_pipe = 2'b00;
  int stb_len = 0;
  bit stb_prev = 0, rq_prev = 0, ack_prev_low = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_oe_o) check("R5 drive only after ack low", {31'd0, !busack_n_i && ack_prev_low}, 1);
      if (rq_prev && !busrq_oe_o) check("R8 drivers off with request", {31'd0, bus_oe_o}, 0);
      if (!bus_rd_n_o || !bus_wr_n_o) begin
        if (stb_len == 0) begin
          check("R6 address", {16'd0, bus_addr_o}, {16'd0, cur_addr});
          check("R6 io strobe", {31'd0, !bus_iorq_n_o}, {31'd0, cur_io});
          check("R6 mem strobe", {31'd0, !bus_mreq_n_o}, {31'd0, !cur_io});
          check("R6 write strobe", {31'd0, !bus_wr_n_o}, {31'd0, cur_wr});
          if (cur_wr) check("R6 write data", {23'd0, bus_dout_oe_o, bus_dout_o}, {23'd0, 1'b1, cur_data});
        end
        if (!bus_wr_n_o) begin
          if (!bus_iorq_n_o) iom[bus_addr_o[7:0]] = bus_dout_o;
          else               mem[bus_addr_o[7:0]] = bus_dout_o;
        end
        stb_len++;
      end else if (stb_prev) begin
        check("R6 strobe width", stb_len, STB_CYC);
        stb_len = 0;
        xfer_cnt++;
      end
      stb_prev = !bus_rd_n_o || !bus_wr_n_o;
    end
    rq_prev = busrq_oe_o;
    ack_prev_low = !busack_n_i;
    ack_pipe = {ack_pipe[0], busrq_oe_o && rst_n};
    busack_n_i = !ack_pipe[1];
  end

  task automatic cpu_write(input logic [4:0] idx, input logic [7:0] d, input int dly);
    cpu_addr_i = {3'(PORT_BASE), idx};
    cpu_data_i = d;
    cpu_iorq_n_i = 0; cpu_wr_n_i = 0;
    #1 check("R2 wait same cycle", {31'd0, cpu_wait_n_o}, 0);
    tick;
    check("R2 valid", {31'd0, wp_valid_o}, 1);
    check("R2 index/data", {19'd0, wp_idx_o, wp_data_o}, {19'd0, idx, d});
    for (int k = 0; k < dly; k++) begin
      check("R2 wait held", {31'd0, cpu_wait_n_o}, 0);
      tick;
    end
    wp_ready_i = 1;
    tick;
    wp_ready_i = 0;
    check("R2 wait released", {30'd0, cpu_wait_n_o, wp_valid_o}, {30'd0, 2'b10});
    cpu_iorq_n_i = 1; cpu_wr_n_i = 1;
    tick;
  endtask

  task automatic cpu_read(input logic [4:0] idx, input int dly);
    cpu_addr_i = {3'(PORT_BASE), idx};
    cpu_iorq_n_i = 0; cpu_rd_n_i = 0;
    #1 check("R3 wait same cycle", {31'd0, cpu_wait_n_o}, 0);
    tick;
    check("R3 request", {26'd0, rp_req_o, rp_idx_o}, {26'd0, 1'b1, idx});
    for (int k = 0; k < dly; k++) begin
      check("R3 wait held", {31'd0, cpu_wait_n_o}, 0);
      tick;
    end
    rp_data_i = port_val(idx);
    rp_valid_i = 1;
    tick;
    rp_valid_i = 0;
    check("R3 data driven", {22'd0, cpu_wait_n_o, bus_dout_oe_o, bus_dout_o}, {22'd0, 2'b11, port_val(idx)});
    cpu_iorq_n_i = 1; cpu_rd_n_i = 1;
    #1 check("R3 drive stops", {31'd0, bus_dout_oe_o}, 0);
    tick;
  endtask

  task automatic cpu_ignored(input string req, input logic [7:0] a, input bit io, input bit rd);
    cpu_addr_i = a;
    cpu_iorq_n_i = !io; cpu_rd_n_i = !rd; cpu_wr_n_i = rd;
    #1 check(req, {31'd0, cpu_wait_n_o}, 1);
    for (int k = 0; k < 3; k++) begin
      tick;
      check(req, {29'd0, cpu_wait_n_o, wp_valid_o, rp_req_o}, {29'd0, 3'b100});
    end
    cpu_iorq_n_i = 1; cpu_rd_n_i = 1; cpu_wr_n_i = 1;
    tick;
  endtask

  task automatic dma(input bit wr, input bit io, input logic [15:0] a, input logic [7:0] d,
                     input bit hold, input int rdly);
    int x0;
    logic [7:0] exp;
    x0 = xfer_cnt;
    exp = io ? sh_io[a[7:0]] : sh_mem[a[7:0]];
    if (wr) begin
      if (io) sh_io[a[7:0]] = d; else sh_mem[a[7:0]] = d;
    end
    cur_wr = wr; cur_io = io; cur_addr = a; cur_data = d;
    cmd_wr_i = wr; cmd_io_i = io; cmd_addr_i = a; cmd_data_i = d; cmd_hold_i = hold;
    cmd_valid_i = 1;
    #1;
    while (!cmd_ready_o) tick;
    tick;
    cmd_valid_i = 0;
    if (!wr) begin
      while (!rsp_valid_o) tick;
      for (int k = 0; k < rdly; k++) tick;
      check("R7 result held", {23'd0, rsp_valid_o, rsp_data_o}, {23'd0, 1'b1, exp});
      rsp_ready_i = 1;
      tick;
      rsp_ready_i = 0;
    end else begin
      while (xfer_cnt == x0) tick;
    end
    check(hold ? "R8 bus kept" : "R8 bus released", {30'd0, busrq_oe_o, bus_oe_o}, hold ? 2 'b11 : 2'b00);
  endtask

  int n;
  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(8'(i), 0); sh_mem[i] = mem[i];
      iom[i] = init_val(8'(i), 1); sh_io[i] = iom[i];
    end
    rst_n = 0; cpu_addr_i = 0; cpu_data_i = 0;
    cpu_iorq_n_i = 1; cpu_rd_n_i = 1; cpu_wr_n_i = 1;
    wp_ready_i = 0; rp_valid_i = 0; rp_data_i = 0;
    cmd_valid_i = 0; cmd_wr_i = 0; cmd_io_i = 0; cmd_hold_i = 0; cmd_addr_i = 0; cmd_data_i = 0;
    rsp_ready_i = 0; irq_req_i = 0; nmi_req_i = 0;
    repeat (3) tick;
    check("R1 reset outputs",
          {24'd0, cpu_wait_n_o, busrq_oe_o, bus_oe_o, bus_dout_oe_o, irq_n_o, nmi_n_o, 1'b0},
          {24'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0});
    check("R1 strobes idle", {28'd0, bus_mreq_n_o, bus_iorq_n_o, bus_rd_n_o, bus_wr_n_o}, 32'hF);
    rst_n = 1;
    tick;

    // directed slave corners
    cpu_write(5'd0, 8'h00, 0);
    cpu_write(5'd31, 8'hFF, 3);
    cpu_read(5'd31, 0);
    cpu_read(5'd0, 4);
    cpu_ignored("R4 below window", {3'(PORT_BASE - 1), 5'd31}, 1, 0);
    cpu_ignored("R4 above window", {3'(PORT_BASE + 1), 5'd0}, 1, 1);
    cpu_ignored("R4 no io strobe", {3'(PORT_BASE), 5'd7}, 0, 0);
    for (int i = 0; i < 16; i++) begin
      if ($urandom % 2) cpu_write(5'($urandom), 8'($urandom), $urandom % 4);
      else              cpu_read(5'($urandom), $urandom % 4);
    end

    // interrupts
    irq_req_i = 2'b10;
    tick;
    check("R9 irq levels", {30'd0, irq_n_o}, {30'd0, 2'b01});
    irq_req_i = 2'b01;
    tick;
    check("R9 irq levels", {30'd0, irq_n_o}, {30'd0, 2'b10});
    irq_req_i = 2'b00;
    nmi_req_i = 1;
    tick;
    for (int k = 0; k < 9; k++) tick;   // request held beyond the pulse
    nmi_req_i = 0;
    tick;
    check("R9 nmi single pulse", {31'd0, nmi_n_o}, 1);
    nmi_req_i = 1;
    tick;
    n = 0;
    while (!nmi_n_o && n < 50) begin n++; tick; end
    check("R9 nmi width", n, NMI_W);
    nmi_req_i = 0;
    tick;

    // DMA: directed then random
    dma(1, 0, 16'h1234, 8'h5C, 0, 0);
    dma(0, 0, 16'h1234, 8'h00, 0, 3);
    dma(1, 1, 16'h00FE, 8'h81, 1, 0);
    dma(0, 1, 16'h00FE, 8'h00, 1, 2);
    // R10: bus held by the block, processor-side decode suspended
    cpu_ignored("R10 decode off while granted", {3'(PORT_BASE), 5'd9}, 1, 0);
    dma(0, 0, 16'h0077, 8'h00, 0, 0);
    for (int k = 0; k < 6; k++) tick;
    check("R8 idle after ack high", {30'd0, busrq_oe_o, busack_n_i}, {30'd0, 2'b01});
    for (int i = 0; i < 20; i++) begin
      dma($urandom % 2, $urandom % 2, {8'($urandom), 5'($urandom % 8), 3'($urandom)},
          8'($urandom), (i < 19) ? ($urandom % 2) : 1'b0, $urandom % 3);
    end
    for (int k = 0; k < 6; k++) tick;
    cpu_write(5'd17, 8'h3C, 1);   // processor regains port access after release

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule